// File: doc/BRIEF.md
# Backup Battery Health Check Sequencer

This block is a host-side state machine that finds out, right after the supply comes back, whether a battery-backed memory kept its contents. A memory of this kind refuses its second access after each power restoration when every one of its backup cells has sagged below 2.0 V. One good cell is enough for the access to go through. The sequencer turns that behaviour into a verdict. It reads one chosen byte and keeps it. It writes the complement of that byte to the same address, then reads the address back. If the read matches the complement, the battery is judged good. If it does not, the memory contents are flagged as questionable.

The verdict only means something when these are the very first memory cycles after the supply is restored. The system therefore starts the sequencer before any other agent touches the memory. Once the verdict is known, the original byte is put back. On the passing path that restore is also read back and verified. The verdict stays in sticky flags until the next accepted start. All memory traffic goes through a cycle controller's request port: request, write flag, address, write data, read data and a one-cycle completion strobe. The memory timing itself belongs to that controller.

States: IDLE (waiting for start), RD_ORIG (read of the saved byte), WR_INV (write of the complement), RD_CHK (read-back and compare), WR_RST (write back of the original), RD_RST (verify of the restore). Transitions: IDLE to RD_ORIG on start. RD_ORIG to WR_INV on completion, saving the byte. WR_INV to RD_CHK on completion. RD_CHK to WR_RST on completion, recording the compare result. WR_RST to RD_RST on completion when the compare matched, or to IDLE with the questionable flag set when it did not. RD_RST to IDLE on completion, setting the good flag on a match or the questionable flag on a mismatch.

Top module: `batt_check_seq`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, mem_req_o, batt_good_o and data_suspect_o are all 0.
- R2: A start_i seen while idle latches test_addr_i. The first memory operation is then a read (mem_we_o=0) of that address, and the returned byte is saved.
- R3: The second operation is a write (mem_we_o=1) to the same address, with write data equal to the bitwise complement of the saved byte.
- R4: The third operation is a read of the same address, compared with the complemented byte. A mismatch leads to batt_good_o=0 and data_suspect_o=1.
- R5: When the third read matches, the fourth operation writes the saved byte back and a fifth reads it. batt_good_o is set only if that fifth read equals the saved byte; otherwise data_suspect_o is set.
- R6: When the third read mismatches, the fourth operation writes the saved byte back and the sequence ends with no further operation.
- R7: done_o pulses high for exactly one cycle when the sequence ends. busy_o is low in that cycle, and at most one of batt_good_o and data_suspect_o is high at any time.
- R8: The status flags hold their value after the sequence ends. Both are cleared in the cycle after an accepted start.
- R9: start_i and test_addr_i are ignored while busy_o is high. The address in use stays stable and no extra operations are issued.
- R10: mem_req_o stays high from the start of an operation until mem_done_i. The write flag and address only change after a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check (accepted only when idle) |
| test_addr_i | input | ADDR_W | Location to test |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| batt_good_o | output | 1 | Sticky: battery judged good |
| data_suspect_o | output | 1 | Sticky: memory contents questionable |
| mem_req_o | output | 1 | Memory operation request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data, valid with mem_done_i |
| mem_done_i | input | 1 | Operation complete strobe |

## Verification
The sequencer runs against a memory model with a healthy battery, using the bytes 0x5A, 0x00 and 0xFF at several addresses. The all-zero and all-one bytes show that the complement flips every bit and that the restore puts the exact original back. A model that drops the second operation after power-up stands in for dead cells. It has to produce the questionable verdict and the shortened four-operation sequence. A model that drops only the restore write separates the first compare from the restore verify. A start and a new address given in the middle of a run show that both are ignored, and waiting after completion and then restarting shows that the flags are sticky and get cleared.

// File: rtl/batt_chk_pkg.sv
package batt_chk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_ORIG = 3'd1,
        ST_WR_INV  = 3'd2,
        ST_RD_CHK  = 3'd3,
        ST_WR_RST  = 3'd4,
        ST_RD_RST  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/bchk_fsm.sv
module bchk_fsm
    import batt_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mem_done_i,
    input  logic       match_i,
    output seq_state_t state_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       good_o,
    output logic       suspect_o,
    output logic       load_o,
    output logic       save_o
);
    seq_state_t state_q, state_d;
    logic chk_ok_q;

    assign state_o = state_q;
    assign busy_o  = (state_q != ST_IDLE);
    assign load_o  = (state_q == ST_IDLE) && start_i;
    assign save_o  = (state_q == ST_RD_ORIG) && mem_done_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)    state_d = ST_RD_ORIG;
            ST_RD_ORIG: if (mem_done_i) state_d = ST_WR_INV;
            ST_WR_INV:  if (mem_done_i) state_d = ST_RD_CHK;
            ST_RD_CHK:  if (mem_done_i) state_d = ST_WR_RST;
            ST_WR_RST:  if (mem_done_i) state_d = chk_ok_q ? ST_RD_RST : ST_IDLE;
            ST_RD_RST:  if (mem_done_i) state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o    <= 1'b0;
            good_o    <= 1'b0;
            suspect_o <= 1'b0;
            chk_ok_q  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_o) begin
                good_o    <= 1'b0;
                suspect_o <= 1'b0;
                chk_ok_q  <= 1'b0;
            end
            if (state_q == ST_RD_CHK && mem_done_i)
                chk_ok_q <= match_i;
            if (state_q == ST_WR_RST && mem_done_i && !chk_ok_q) begin
                suspect_o <= 1'b1;
                done_o    <= 1'b1;
            end
            if (state_q == ST_RD_RST && mem_done_i) begin
                good_o    <= match_i;
                suspect_o <= !match_i;
                done_o    <= 1'b1;
            end
        end
    end

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R7
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({good_o, suspect_o}));
    // R8
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (!good_o && !suspect_o && busy_o));
    // R8
    status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i && !done_o) |=> ($stable(good_o) && $stable(suspect_o)));
endmodule

// File: rtl/bchk_dp.sv
module bchk_dp
    import batt_chk_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_i,
    input  logic              load_i,
    input  logic              save_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              match_o
);
    logic [DATA_W-1:0] saved_q;
    logic [DATA_W-1:0] inv_w;
    logic [DATA_W-1:0] expect_w;
    logic              use_inv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o  <= '0;
            saved_q <= '0;
        end else begin
            if (load_i) addr_o  <= addr_i;
            if (save_i) saved_q <= rdata_i;
        end
    end

    assign inv_w    = ~saved_q;
    assign use_inv  = (state_i == ST_WR_INV) || (state_i == ST_RD_CHK);
    assign expect_w = use_inv ? inv_w : saved_q;
    assign wdata_o  = expect_w;
    assign match_o  = (rdata_i == expect_w);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_IDLE) |=> (state_i == ST_IDLE || $stable(addr_o)));
endmodule

// File: rtl/batt_check_seq.sv
module batt_check_seq
    import batt_chk_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] test_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              batt_good_o,
    output logic              data_suspect_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_done_i
);
    seq_state_t state_w;
    logic load_w, save_w, match_w;

    bchk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mem_done_i(mem_done_i), .match_i(match_w),
        .state_o(state_w), .busy_o(busy_o), .done_o(done_o),
        .good_o(batt_good_o), .suspect_o(data_suspect_o),
        .load_o(load_w), .save_o(save_w)
    );

    bchk_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .state_i(state_w),
        .load_i(load_w), .save_i(save_w), .addr_i(test_addr_i),
        .rdata_i(mem_rdata_i), .addr_o(mem_addr_o),
        .wdata_o(mem_wdata_o), .match_o(match_w)
    );

    assign mem_req_o = busy_o;
    assign mem_we_o  = (state_w == ST_WR_INV) || (state_w == ST_WR_RST);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_done_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));
    // R3
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_req_o);
endmodule

// File: tb/batt_check_seq_tb_top.sv
`timescale 1ns/100ps
module batt_check_seq_tb_top;
    localparam int AW = 15;
    localparam int DW = 8;

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        string         tag;
    } op_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [AW-1:0] test_addr_i = '0;
    logic busy_o, done_o, batt_good_o, data_suspect_o;
    logic mem_req_o, mem_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic mem_done_i = 1'b0;

    int total = 0;
    int bad = 0;
    op_t exp_q[$];

    logic [DW-1:0] mem [0:255];
    bit   batt_low = 0;
    bit   drop_restore = 0;
    int   opnum = 0;
    bit   active = 0;
    int   lat = 0;

    always #2.5 clk = ~clk;

    batt_check_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .test_addr_i(test_addr_i),
        .busy_o(busy_o), .done_o(done_o), .batt_good_o(batt_good_o),
        .data_suspect_o(data_suspect_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_done_i(mem_done_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // memory model: two-cycle latency, optional dropped writes
    always @(posedge clk) begin
        mem_done_i <= 1'b0;
        if (!active && mem_req_o && !mem_done_i) begin
            active <= 1;
            lat    <= 2;
        end else if (active) begin
            if (lat == 0) begin
                active     <= 0;
                mem_done_i <= 1'b1;
                if (mem_we_o) begin
                    if (!(batt_low && opnum == 1) && !(drop_restore && opnum == 3))
                        mem[mem_addr_o[7:0]] <= mem_wdata_o;
                end else begin
                    mem_rdata_i <= mem[mem_addr_o[7:0]];
                end
                opnum <= opnum + 1;
            end else begin
                lat <= lat - 1;
            end
        end
    end

    // monitor: compare each completed operation with the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_req_o && mem_done_i) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected extra op", int'(mem_addr_o), 0);
            end else begin
                op_t e;
                e = exp_q.pop_front();
                check(mem_we_o == e.we, {e.tag, " op kind"}, int'(mem_we_o), int'(e.we));
                check(mem_addr_o == e.addr, {e.tag, " op addr"}, int'(mem_addr_o), int'(e.addr));
                if (e.we)
                    check(mem_wdata_o == e.wd, {e.tag, " op data"}, int'(mem_wdata_o), int'(e.wd));
            end
        end
    end

    task automatic push_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        op_t o;
        o.we = we; o.addr = a; o.wd = d; o.tag = tag;
        exp_q.push_back(o);
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_check(input logic [AW-1:0] a, input logic [DW-1:0] b,
                             input bit low, input bit drop, input bit poke_busy);
        bit exp_good;
        mem[a[7:0]] = b;
        batt_low = low;
        drop_restore = drop;
        opnum = 0;
        exp_good = !low && !drop;
        push_op(0, a, '0, "R2");
        push_op(1, a, ~b, "R3");
        push_op(0, a, '0, "R4");
        push_op(1, a, b, low ? "R6" : "R5");
        if (!low) push_op(0, a, '0, "R5");
        @(negedge clk);
        test_addr_i = a;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !batt_good_o && !data_suspect_o, "R8 cleared on start",
              {busy_o, batt_good_o, data_suspect_o}, 3'b100);
        if (poke_busy) begin
            repeat (5) @(negedge clk);
            test_addr_i = a ^ 15'h0055;
            start_i = 1'b1;
            repeat (3) @(negedge clk);
            start_i = 1'b0;
        end
        wait_done();
        check(done_o && !busy_o, "R7 done pulse", {done_o, busy_o}, 2'b10);
        check(batt_good_o == exp_good && data_suspect_o == !exp_good, "R4 R5 verdict",
              {batt_good_o, data_suspect_o}, {exp_good, !exp_good});
        @(negedge clk);
        check(!done_o, "R7 single cycle", done_o, 0);
        check(exp_q.size() == 0, "R6 op count", exp_q.size(), 0);
        check(mem[a[7:0]] == (drop ? ~b : b), "R5 restored byte", mem[a[7:0]], drop ? ~b : b);
        repeat (10) @(negedge clk);
        check(batt_good_o == exp_good && data_suspect_o == !exp_good && !mem_req_o,
              "R8 sticky", {batt_good_o, data_suspect_o}, {exp_good, !exp_good});
        exp_q.delete();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !mem_req_o && !batt_good_o && !data_suspect_o,
              "R1 reset state", {busy_o, done_o, mem_req_o, batt_good_o, data_suspect_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!mem_req_o && !busy_o, "R1 idle after reset", mem_req_o, 0);
        run_check(15'h0012, 8'h5A, 0, 0, 0);
        run_check(15'h00F0, 8'h00, 0, 0, 0);
        run_check(15'h0033, 8'hFF, 0, 0, 0);
        run_check(15'h0041, 8'hC3, 1, 0, 0);
        run_check(15'h0007, 8'h96, 0, 1, 0);
        run_check(15'h0021, 8'h3C, 0, 0, 1);
        run_check(15'h0065, 8'hA5, 1, 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule